// File: doc/BRIEF.md
# Operand Read-Miss Fill Controller

This block runs the bus side of an operand read that missed in the data cache. A request is either a single word read or a full cache line. A full line is fetched as a four-beat burst that starts at the requested word and wraps around inside the line. Each beat ends when the bus returns either an acknowledge or a transfer error. The block picks one of three outcomes: it raises an access-error exception, it hands a complete line to the cache for writing, or it quietly discards the partly fetched line.

The word that was asked for arrives on the first beat and goes to the core at once. The cache write happens only once all four beats have been acknowledged. An error on the first beat is reported in the same way as an error on a single-word read. An error on any later beat raises nothing: the fill is abandoned, and the block keeps no memory of it. A later access to that line therefore misses again and goes back out to the bus. If that new access errors on its first beat, the exception is raised at that point. The cache arrays themselves sit outside this block.

Top module: `line_fill_err_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `req_ready` is 1 and `bus_req`, `op_valid`, `cache_we` and `exc_req` are all 0.
- R2: A word read (`req_line`=0) is accepted when `req_ready` is 1. It drives exactly one beat, with `bus_addr` equal to the request address and `bus_burst`=0. The cycle after that beat is acknowledged, `op_valid` is 1 with the bus data and `cache_we` stays 0.
- R3: A line request drives four beats with `bus_burst`=1. The address of beat i (i = 0..3) keeps the request's bits above bit 3, puts ((request bits [3:2]) + i) mod 4 into bits [3:2], and clears bits [1:0].
- R4: The cycle after the first beat of a line is acknowledged, `op_valid` is 1 for one cycle and `op_data` equals that beat's data.
- R5: The cycle after the fourth beat is acknowledged, `cache_we` is 1 for one cycle. In that cycle `cache_addr` is the request address with bits [3:0] cleared, and word w of `cache_line` (bits [32w+31:32w]) holds the data of the beat that fetched word w.
- R6: A transfer error on the single beat of a word read makes `exc_req` 1 for one cycle, with `exc_addr` equal to the request address. No `op_valid` follows.
- R7: A transfer error on the first beat of a line raises `exc_req` as in R6. No `op_valid` and no `cache_we` follow.
- R8: A transfer error on beat 2, 3 or 4 of a line raises no `exc_req` and no `cache_we`. `bus_req` drops in the following cycle and `req_ready` returns to 1.
- R9: A beat counts as an error only when `bus_err` is 1 and `bus_ack` is 0. When both are 1, the beat is treated as acknowledged.
- R10: While a beat gets neither acknowledge nor error, `bus_req` stays 1 and `bus_addr` does not change. A `req_valid` raised while busy is ignored.
- R11: After a line is dropped (R8), a new request to the same line drives a fresh four-beat burst. An error on that burst's first beat then raises `exc_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read-miss request strobe |
| req_addr | input | ADDR_W | Byte address of the missed operand |
| req_line | input | 1 | 1 = fetch whole line, 0 = single word |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| bus_req | output | 1 | A beat is outstanding on the bus |
| bus_addr | output | ADDR_W | Address of the outstanding beat |
| bus_burst | output | 1 | Outstanding transfer is part of a line burst |
| bus_ack | input | 1 | Beat acknowledged, data valid |
| bus_err | input | 1 | Beat terminated with transfer error |
| bus_data | input | DATA_W | Read data of the beat |
| op_valid | output | 1 | Requested operand returned to core |
| op_data | output | DATA_W | Operand data |
| cache_we | output | 1 | Write a complete line into the cache |
| cache_addr | output | ADDR_W | Line-aligned address for the cache write |
| cache_line | output | BEATS*DATA_W | Assembled line, word w at w*DATA_W |
| exc_req | output | 1 | Access-error exception request |
| exc_addr | output | ADDR_W | Address of the faulting request |

## Verification
The hardest case to reach is the silent drop followed by a re-raise. An error has to land on a middle beat of a wrapped burst, the block must then show no trace of it, and a later request to the same line must be the one that raises the exception. Directed sequences produce this: an error on beat 2, 3 and 4 with several wrap start words, followed at once by a new request to the same line whose first beat errors, and then by a clean refill. A random run follows that mixes wait states, simultaneous ack and error, and stray requests while busy. A cycle-accurate model checks every output on every clock.

// File: rtl/lfe_pkg.sv
package lfe_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } lfe_state_t;
endpackage

// File: rtl/lfe_seq.sv
// Beat sequencer: accepts a request, walks the wrapped burst, flags events.
module lfe_seq
  import lfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int OFFB  = $clog2(DATA_W / 8),
  localparam int WB    = $clog2(BEATS),
  localparam int LOWB  = OFFB + WB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_line,
  output logic              req_ready,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_burst,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              ev_ack,
  output logic              ev_err,
  output logic              ev_first,
  output logic              ev_last,
  output logic              ev_line,
  output logic [WB-1:0]     ev_slot,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-LOWB-1:0] line_tag
);
  lfe_state_t        state;
  logic [WB-1:0]     beat;
  logic              line_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WB-1:0]     slot_now;
  logic [WB-1:0]     slot_nxt;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] start_addr;

  always_comb begin
    slot_now   = base_q[OFFB +: WB] + beat;
    slot_nxt   = slot_now + WB'(1);
    ev_ack     = (state == ST_FETCH) && bus_ack;
    ev_err     = (state == ST_FETCH) && bus_err && !bus_ack;
    ev_first   = (beat == '0);
    ev_last    = !line_q || (beat == WB'(BEATS - 1));
    next_addr  = {base_q[ADDR_W-1:LOWB], slot_nxt, {OFFB{1'b0}}};
    start_addr = req_line ? {req_addr[ADDR_W-1:OFFB], {OFFB{1'b0}}} : req_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      beat   <= '0;
      line_q <= 1'b0;
      base_q <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state  <= ST_FETCH;
            beat   <= '0;
            line_q <= req_line;
            base_q <= req_addr;
            addr_q <= start_addr;
          end
        end
        default: begin
          if (ev_ack) begin
            if (ev_last) begin
              state <= ST_IDLE;
            end else begin
              beat   <= beat + WB'(1);
              addr_q <= next_addr;
            end
          end else if (ev_err) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign bus_req   = (state == ST_FETCH);
  assign bus_addr  = addr_q;
  assign bus_burst = line_q;
  assign ev_line   = line_q;
  assign ev_slot   = slot_now;
  assign cur_addr  = base_q;
  assign line_tag  = base_q[ADDR_W-1:LOWB];
endmodule

// File: rtl/lfe_line_buf.sv
// Line assembly buffer: one word register per slot, write strobe on completion.
module lfe_line_buf #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int OFFB  = $clog2(DATA_W / 8),
  localparam int WB    = $clog2(BEATS),
  localparam int LOWB  = OFFB + WB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ev_ack,
  input  logic                    ev_line,
  input  logic                    ev_last,
  input  logic [WB-1:0]           ev_slot,
  input  logic [DATA_W-1:0]       bus_data,
  input  logic [ADDR_W-LOWB-1:0]  line_tag,
  output logic                    cache_we,
  output logic [ADDR_W-1:0]       cache_addr,
  output logic [BEATS*DATA_W-1:0] cache_line
);
  logic fill_done;
  assign fill_done = ev_ack && ev_line && ev_last;

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (ev_ack && ev_line && (ev_slot == WB'(g))) word_q <= bus_data;
    end
    assign cache_line[g*DATA_W +: DATA_W] = word_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cache_we   <= 1'b0;
      cache_addr <= '0;
    end else begin
      cache_we <= fill_done;
      if (fill_done) cache_addr <= {line_tag, {LOWB{1'b0}}};
    end
  end
endmodule

// File: rtl/lfe_resp.sv
// Core response: critical operand forwarding and exception request.
module lfe_resp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_ack,
  input  logic              ev_err,
  input  logic              ev_first,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              op_valid,
  output logic [DATA_W-1:0] op_data,
  output logic              exc_req,
  output logic [ADDR_W-1:0] exc_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      exc_req  <= 1'b0;
      op_data  <= '0;
      exc_addr <= '0;
    end else begin
      op_valid <= ev_ack && ev_first;
      exc_req  <= ev_err && ev_first;
      if (ev_ack && ev_first) op_data <= bus_data;
      if (ev_err && ev_first) exc_addr <= cur_addr;
    end
  end
endmodule

// File: rtl/line_fill_err_ctrl.sv
module line_fill_err_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4,
  localparam int OFFB  = $clog2(DATA_W / 8),
  localparam int WB    = $clog2(BEATS),
  localparam int LOWB  = OFFB + WB
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_line,
  output logic                    req_ready,
  output logic                    bus_req,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic                    bus_burst,
  input  logic                    bus_ack,
  input  logic                    bus_err,
  input  logic [DATA_W-1:0]       bus_data,
  output logic                    op_valid,
  output logic [DATA_W-1:0]       op_data,
  output logic                    cache_we,
  output logic [ADDR_W-1:0]       cache_addr,
  output logic [BEATS*DATA_W-1:0] cache_line,
  output logic                    exc_req,
  output logic [ADDR_W-1:0]       exc_addr
);
  logic                   ev_ack, ev_err, ev_first, ev_last, ev_line;
  logic [WB-1:0]          ev_slot;
  logic [ADDR_W-1:0]      cur_addr;
  logic [ADDR_W-LOWB-1:0] line_tag;

  lfe_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_line(req_line), .req_ready(req_ready),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .ev_ack(ev_ack), .ev_err(ev_err), .ev_first(ev_first), .ev_last(ev_last),
    .ev_line(ev_line), .ev_slot(ev_slot), .cur_addr(cur_addr), .line_tag(line_tag)
  );

  lfe_line_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_buf (
    .clk(clk), .rst(rst),
    .ev_ack(ev_ack), .ev_line(ev_line), .ev_last(ev_last), .ev_slot(ev_slot),
    .bus_data(bus_data), .line_tag(line_tag),
    .cache_we(cache_we), .cache_addr(cache_addr), .cache_line(cache_line)
  );

  lfe_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst),
    .ev_ack(ev_ack), .ev_err(ev_err), .ev_first(ev_first),
    .bus_data(bus_data), .cur_addr(cur_addr),
    .op_valid(op_valid), .op_data(op_data), .exc_req(exc_req), .exc_addr(exc_addr)
  );
endmodule

// File: rtl/lfe_checker.sv
module lfe_checker #(
  parameter int ADDR_W = 32,
  parameter int BEATS  = 4,
  localparam int CW    = $clog2(BEATS) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              op_valid,
  input logic              cache_we,
  input logic              exc_req
);
  logic [CW-1:0] acks;
  always_ff @(posedge clk) begin
    if (rst) acks <= '0;
    else if (req_valid && req_ready) acks <= '0;
    else if (bus_req && bus_ack) acks <= acks + CW'(1);
  end

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (req_ready && !bus_req && !cache_we && !exc_req)); // R1
  AST_OP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) op_valid |-> $past(bus_req && bus_ack)); // R4
  AST_FULL_LINE: assert property (@(posedge clk) disable iff (rst) cache_we |-> (acks == CW'(BEATS))); // R5
  AST_EXC_AFTER_ERR: assert property (@(posedge clk) disable iff (rst) exc_req |-> $past(bus_req && bus_err && !bus_ack)); // R6
  AST_EXC_NO_OP: assert property (@(posedge clk) disable iff (rst) !(exc_req && (op_valid || cache_we))); // R7
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst) (bus_req && bus_err && !bus_ack) |=> (!bus_req && req_ready)); // R8
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst) (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr))); // R10
endmodule

bind line_fill_err_ctrl lfe_checker #(.ADDR_W(ADDR_W), .BEATS(BEATS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
  .op_valid(op_valid), .cache_we(cache_we), .exc_req(exc_req)
);

// File: tb/test_line_fill_err_ctrl.sv
`timescale 1ns/1ps
module test_line_fill_err_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_line = 1'b0, bus_ack = 1'b0, bus_err = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] bus_data = '0;
  logic req_ready, bus_req, bus_burst, op_valid, cache_we, exc_req;
  logic [AW-1:0] bus_addr, cache_addr, exc_addr;
  logic [DW-1:0] op_data;
  logic [NB*DW-1:0] cache_line;

  always #2.5 clk = ~clk;

  line_fill_err_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BEATS(NB)) i_line_fill_err_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_line(req_line),
    .req_ready(req_ready), .bus_req(bus_req), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_data(bus_data),
    .op_valid(op_valid), .op_data(op_data), .cache_we(cache_we), .cache_addr(cache_addr),
    .cache_line(cache_line), .exc_req(exc_req), .exc_addr(exc_addr)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state
  bit m_busy = 0, m_line = 0, m_op = 0, m_we = 0, m_exc = 0;
  int m_beat = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_opd = '0;
  logic [DW-1:0] m_words [NB];

  task automatic chk(input bit ok, input string what, input logic [NB*DW-1:0] act, input logic [NB*DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_bus_addr();
    logic [1:0] s;
    s = 2'((int'(m_addr[3:2]) + m_beat) % 4);
    return m_line ? {m_addr[AW-1:4], s, 2'b00} : m_addr;
  endfunction

  task automatic model_update();
    if (rst) begin
      m_busy = 0; m_op = 0; m_we = 0; m_exc = 0; m_beat = 0;
    end else begin
      m_op = 0; m_we = 0; m_exc = 0;
      if (!m_busy) begin
        if (req_valid) begin
          m_busy = 1; m_line = req_line; m_addr = req_addr; m_beat = 0;
        end
      end else if (bus_ack) begin
        m_words[(int'(m_addr[3:2]) + m_beat) % 4] = bus_data;
        if (m_beat == 0) begin m_op = 1; m_opd = bus_data; end
        if (!m_line) m_busy = 0;
        else if (m_beat == 3) begin m_we = 1; m_busy = 0; end
        else m_beat++;
      end else if (bus_err) begin
        if (m_beat == 0) m_exc = 1;
        m_busy = 0;
      end
    end
  endtask

  task automatic compare();
    chk(req_ready == !m_busy, "req_ready", req_ready, !m_busy);
    chk(bus_req == m_busy, "bus_req", bus_req, m_busy);
    if (m_busy) begin
      chk(bus_burst == m_line, "bus_burst", bus_burst, m_line);
      chk(bus_addr == exp_bus_addr(), "bus_addr", bus_addr, exp_bus_addr());
    end
    chk(op_valid == m_op, "op_valid", op_valid, m_op);
    if (m_op) chk(op_data == m_opd, "op_data", op_data, m_opd);
    chk(cache_we == m_we, "cache_we", cache_we, m_we);
    if (m_we) begin
      chk(cache_addr == {m_addr[AW-1:4], 4'b0}, "cache_addr", cache_addr, {m_addr[AW-1:4], 4'b0});
      chk(cache_line == {m_words[3], m_words[2], m_words[1], m_words[0]}, "cache_line",
          cache_line, {m_words[3], m_words[2], m_words[1], m_words[0]});
    end
    chk(exc_req == m_exc, "exc_req", exc_req, m_exc);
    if (m_exc) chk(exc_addr == m_addr, "exc_addr", exc_addr, m_addr);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_update();
    compare();
  endtask

  // code per beat: 0 = ack, 1 = error, 2 = ack and error together
  task automatic xfer(input logic [AW-1:0] a, input bit ln, input int c0, input int c1,
                      input int c2, input int c3, input int waits, input string tag);
    int cd [4];
    cd = '{c0, c1, c2, c3};
    cur_tag = tag;
    req_valid = 1; req_addr = a; req_line = ln;
    step();
    req_valid = 0;
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < waits; w++) begin
        req_valid = 1; req_addr = ~a; req_line = 1'($urandom);   // R10 stray request while busy
        step();
        req_valid = 0;
      end
      bus_data = $urandom;
      bus_ack = (cd[b] != 1);
      bus_err = (cd[b] != 0);
      step();
      bus_ack = 0; bus_err = 0;
      if (cd[b] == 1 || !ln) break;
    end
    step();
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    rst = 1;
    for (int i = 0; i < 3; i++) step();
    rst = 0;
    step();                                            // R1 first cycle after release
    xfer(32'h0000_1004, 0, 0, 0, 0, 0, 0, "R2");
    xfer(32'h0000_2006, 0, 0, 0, 0, 0, 2, "R2");
    xfer(32'h0000_3000, 1, 0, 0, 0, 0, 0, "R3");
    xfer(32'h0000_3008, 1, 0, 0, 0, 0, 1, "R3");
    xfer(32'h0000_400C, 1, 0, 0, 0, 0, 0, "R4");
    xfer(32'h0000_5004, 1, 0, 0, 0, 0, 3, "R5");
    xfer(32'h0000_6002, 0, 1, 0, 0, 0, 0, "R6");
    xfer(32'h0000_6010, 0, 1, 0, 0, 0, 2, "R6");
    xfer(32'h0000_7008, 1, 1, 0, 0, 0, 0, "R7");
    xfer(32'h0000_8004, 1, 0, 1, 0, 0, 0, "R8");
    xfer(32'h0000_8104, 1, 0, 0, 1, 0, 1, "R8");
    xfer(32'h0000_820C, 1, 0, 0, 0, 1, 0, "R8");
    xfer(32'h0000_9000, 1, 2, 2, 0, 2, 0, "R9");
    xfer(32'h0000_9104, 0, 2, 0, 0, 0, 0, "R9");
    xfer(32'h0000_A000, 1, 0, 0, 0, 0, 4, "R10");
    xfer(32'h0000_B008, 1, 0, 0, 1, 0, 0, "R11");     // drop on beat 3
    xfer(32'h0000_B004, 1, 1, 0, 0, 0, 0, "R11");     // same line, first-beat error reports
    xfer(32'h0000_B00C, 1, 0, 1, 0, 0, 0, "R11");
    xfer(32'h0000_B000, 1, 0, 0, 0, 0, 0, "R11");     // clean refill now writes
    for (int k = 0; k < 200; k++) begin
      int c [4];
      for (int j = 0; j < 4; j++) c[j] = ($urandom % 8 == 0) ? 1 : (($urandom % 6 == 0) ? 2 : 0);
      xfer($urandom, 1'($urandom), c[0], c[1], c[2], c[3], $urandom % 3, "R11");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule